// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port

This block sends and receives bytes over a two-wire asynchronous serial line. Software sets the frame options and a baud divisor through a small register write port. Bytes to send arrive on a valid/ready input. Received bytes leave on a one-cycle valid output with a parity-error flag. A single receive interrupt line reports each received byte. While the port is disabled, the same line can instead pulse at every baud counter underflow, so the counter can serve as a periodic timer.

The control word sets these options:
- hardware flow control through a clear-to-send input
- a parity bit and its polarity
- a forced break level on the transmit pin
- one or two stop bits
- an internal loopback path that joins the transmitter to the receiver

Bit timing comes from a down-counter that reloads from the divisor. It produces a 16x oversampling tick. Each serial bit lasts 16 ticks.

Top module: `serial_port`

## Requirements
- R1: After reset every control bit and the divisor are 0, `txd` is 1, and `txReady`, `rxValid`, `rxParityErr` and `rxIrq` are 0.
- R2: Address 0 is the control word. Its bits are: 0 enable, 1 flow-control enable, 2 parity enable, 3 odd parity, 4 break, 5 two stop bits, 6 loopback, 7 baud interrupt. Address 1 is the divisor. The tick period is divisor+1 clocks and one bit lasts 16 ticks. A transmitted frame is a 0 start bit, then 8 data bits least significant first, then stop bits at 1, and the idle level is 1.
- R3: With parity enabled, one parity bit follows the data bits on transmit and the receiver expects one. With parity disabled, none is sent or expected.
- R4: Odd-parity bit 0 selects even parity and 1 selects odd parity, for both directions. A received parity mismatch raises `rxParityErr` in the same cycle as `rxValid`.
- R5: With the two-stop bit at 0, back-to-back frames repeat every 10 bit times, plus one with parity. With it at 1, they repeat one bit time later.
- R6: With flow control enabled, `txReady` is 1 only while `cts` is 1. With it disabled, `cts` is ignored.
- R7: While the break bit is 1, `txd` is 0 from the clock after the write. Any frame in progress is abandoned, so clearing the bit returns `txd` to 1 and `txReady` to 1.
- R8: With loopback on, the transmitted stream reaches the receiver instead of `rxd`, and `txd` stays at 1.
- R9: With enable at 0 and the baud interrupt bit at 1, `rxIrq` pulses once per counter underflow, that is every divisor+1 clocks. With the baud interrupt bit at 0, `rxIrq` stays 0.
- R10: With enable at 1, `rxIrq` equals `rxValid` and the baud interrupt bit has no effect.
- R11: A start bit counts only if the line is still low at mid-bit. A shorter low pulse produces no byte. Each byte is reported by a one-cycle `rxValid` pulse.
- R12: With enable at 0, `txReady` is 0 and activity on `rxd` produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the control word, 1 selects the divisor |
| regWdata | input | 16 | Write data |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Byte offered |
| txReady | output | 1 | Byte accepted when high together with txValid |
| rxData | output | 8 | Received byte, valid with rxValid |
| rxValid | output | 1 | One-cycle pulse per received byte |
| rxParityErr | output | 1 | Parity mismatch on the reported byte |
| txd | output | 1 | Serial transmit pin |
| rxd | input | 1 | Serial receive pin |
| cts | input | 1 | Clear-to-send, high means the far end may receive |
| rxIrq | output | 1 | Receive interrupt |

## Verification
A corrupted transmit state or bit index shows up on `txd` within one bit time as a shifted or missing bit. It also moves the next start edge in back-to-back frames by a whole bit time. A stuck receive state shows up as a missing `rxValid` or a wrong byte one frame after the stimulus. A corrupted baud counter changes the interrupt spacing measured while the port is disabled, within a few periods.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  typedef struct packed {
    logic baudIrq;
    logic loop;
    logic twoStop;
    logic brk;
    logic parOdd;
    logic parEn;
    logic ctsEn;
    logic enable;
  } ctrl_t;

  typedef struct packed {
    logic tick;
    logic enable;
    logic ctsEn;
    logic parEn;
    logic parOdd;
    logic brk;
    logic twoStop;
    logic loop;
  } strobe_t;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP1, TX_STOP2} tx_state_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_t;
endpackage

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
  import serial_port_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regAddr,
  input  logic [DIV_W-1:0] regWdata,
  input  logic             rxValid,
  output ctrl_t            cfg,
  output strobe_t          strb,
  output logic             rxIrq
);
  localparam int CFG_W = $bits(ctrl_t);

  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] baudCnt;
  logic             tickQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      divisor <= '0;
    end else if (regWe) begin
      if (regAddr == 1'b0) cfg <= ctrl_t'(regWdata[CFG_W-1:0]);
      else                 divisor <= regWdata;
    end
  end

  // Down-counter: one tick per underflow, reload from divisor.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baudCnt <= '0;
      tickQ   <= 1'b0;
    end else if (baudCnt == '0) begin
      baudCnt <= divisor;
      tickQ   <= 1'b1;
    end else begin
      baudCnt <= baudCnt - 1'b1;
      tickQ   <= 1'b0;
    end
  end

  always_comb begin
    strb.tick    = tickQ;
    strb.enable  = cfg.enable;
    strb.ctsEn   = cfg.ctsEn;
    strb.parEn   = cfg.parEn;
    strb.parOdd  = cfg.parOdd;
    strb.brk     = cfg.brk;
    strb.twoStop = cfg.twoStop;
    strb.loop    = cfg.loop;
  end

  assign rxIrq = cfg.enable ? rxValid : (cfg.baudIrq & tickQ);
endmodule

// File: rtl/serial_port_dp.sv
module serial_port_dp
  import serial_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  input  logic              cts,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxParityErr
);
  localparam int SUB_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OSR / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  // ---------------- transmitter ----------------
  tx_state_t         txState;
  logic [SUB_W-1:0]  txSub;
  logic [IDX_W-1:0]  txIdx;
  logic [DATA_W-1:0] txShift;
  logic              txPar;
  logic              txLine;
  logic              loopLine;

  assign txReady = strb.enable && !strb.brk && (txState == TX_IDLE) && (!strb.ctsEn || cts);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txSub   <= '0;
      txIdx   <= '0;
      txShift <= '0;
      txPar   <= 1'b0;
    end else if (!strb.enable || strb.brk) begin
      txState <= TX_IDLE;
    end else if (txState == TX_IDLE) begin
      if (txValid && txReady) begin
        txShift <= txData;
        txPar   <= (^txData) ^ strb.parOdd;
        txSub   <= '0;
        txIdx   <= '0;
        txState <= TX_START;
      end
    end else if (strb.tick) begin
      txSub <= (txSub == SUB_LAST) ? '0 : txSub + 1'b1;
      if (txSub == SUB_LAST) begin
        unique case (txState)
          TX_START: txState <= TX_DATA;
          TX_DATA: begin
            txShift <= txShift >> 1;
            txIdx   <= txIdx + 1'b1;
            if (txIdx == IDX_LAST) txState <= strb.parEn ? TX_PAR : TX_STOP1;
          end
          TX_PAR:   txState <= TX_STOP1;
          TX_STOP1: txState <= strb.twoStop ? TX_STOP2 : TX_IDLE;
          TX_STOP2: txState <= TX_IDLE;
          default:  txState <= TX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (txState)
      TX_START: txLine = 1'b0;
      TX_DATA:  txLine = txShift[0];
      TX_PAR:   txLine = txPar;
      default:  txLine = 1'b1;
    endcase
  end

  assign loopLine = strb.brk ? 1'b0 : txLine;
  assign txd      = strb.brk ? 1'b0 : (strb.loop ? 1'b1 : txLine);

  // ---------------- receiver ----------------
  rx_state_t         rxState;
  logic [1:0]        rxSync;
  logic [SUB_W-1:0]  rxSub;
  logic [IDX_W-1:0]  rxIdx;
  logic [DATA_W-1:0] rxShift;
  logic              rxParBit;
  logic              rxLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSync <= 2'b11;
    else       rxSync <= {rxSync[0], rxd};
  end

  assign rxLine = strb.loop ? loopLine : rxSync[1];
  assign rxData = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState     <= RX_IDLE;
      rxSub       <= '0;
      rxIdx       <= '0;
      rxShift     <= '0;
      rxParBit    <= 1'b0;
      rxValid     <= 1'b0;
      rxParityErr <= 1'b0;
    end else begin
      rxValid     <= 1'b0;
      rxParityErr <= 1'b0;
      if (!strb.enable) begin
        rxState <= RX_IDLE;
      end else if (strb.tick) begin
        unique case (rxState)
          RX_IDLE: begin
            if (!rxLine) begin
              rxState <= RX_START;
              rxSub   <= '0;
            end
          end
          RX_START: begin
            if (rxSub == SUB_MID) begin
              rxSub   <= '0;
              rxIdx   <= '0;
              rxState <= rxLine ? RX_IDLE : RX_DATA;
            end else begin
              rxSub <= rxSub + 1'b1;
            end
          end
          RX_DATA: begin
            if (rxSub == SUB_LAST) begin
              rxSub   <= '0;
              rxShift <= {rxLine, rxShift[DATA_W-1:1]};
              rxIdx   <= rxIdx + 1'b1;
              if (rxIdx == IDX_LAST) rxState <= strb.parEn ? RX_PAR : RX_STOP;
            end else begin
              rxSub <= rxSub + 1'b1;
            end
          end
          RX_PAR: begin
            if (rxSub == SUB_LAST) begin
              rxSub    <= '0;
              rxParBit <= rxLine;
              rxState  <= RX_STOP;
            end else begin
              rxSub <= rxSub + 1'b1;
            end
          end
          RX_STOP: begin
            if (rxSub == SUB_LAST) begin
              rxSub       <= '0;
              rxValid     <= 1'b1;
              rxParityErr <= strb.parEn && (rxParBit != ((^rxShift) ^ strb.parOdd));
              rxState     <= RX_IDLE;
            end else begin
              rxSub <= rxSub + 1'b1;
            end
          end
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_port.sv
module serial_port
  import serial_port_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DIV_W-1:0]  regWdata,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxParityErr,
  output logic              txd,
  input  logic              rxd,
  input  logic              cts,
  output logic              rxIrq
);
  ctrl_t   cfg;
  strobe_t strb;

  serial_port_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .rxValid(rxValid), .cfg(cfg), .strb(strb), .rxIrq(rxIrq)
  );

  serial_port_dp #(.DATA_W(DATA_W), .OSR(OSR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData), .txValid(txValid),
    .txReady(txReady), .cts(cts), .txd(txd), .rxd(rxd), .rxData(rxData),
    .rxValid(rxValid), .rxParityErr(rxParityErr)
  );
endmodule

// File: rtl/serial_port_chk.sv
module serial_port_chk
  import serial_port_pkg::*;
(
  input logic  clk,
  input logic  rstN,
  input ctrl_t cfg,
  input logic  cts,
  input logic  txd,
  input logic  txReady,
  input logic  rxValid,
  input logic  rxParityErr,
  input logic  rxIrq
);
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rstN) cfg.brk |-> !txd); // R7
  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (cfg.enable && (!cfg.ctsEn || cts))); // R6
  AST_READY_DISABLED: assert property (@(posedge clk) disable iff (!rstN) !cfg.enable |-> !txReady); // R12
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rstN) rxValid |=> !rxValid); // R11
  AST_PERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN) rxParityErr |-> rxValid); // R4
  AST_LOOP_IDLE: assert property (@(posedge clk) disable iff (!rstN) (cfg.loop && !cfg.brk) |-> txd); // R8
  AST_NO_BAUD_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.enable && !cfg.baudIrq) |-> !rxIrq); // R9
  AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rstN) cfg.enable |-> (rxIrq == rxValid)); // R10
endmodule

bind serial_port serial_port_chk u_chk (
  .clk(clk), .rstN(rstN), .cfg(cfg), .cts(cts), .txd(txd), .txReady(txReady),
  .rxValid(rxValid), .rxParityErr(rxParityErr), .rxIrq(rxIrq)
);

// File: tb/serial_port_tb.sv
module serial_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] regWdata = '0;
  logic [7:0]  txData = '0;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [7:0]  rxData;
  logic        rxValid;
  logic        rxParityErr;
  logic        txd;
  logic        rxd = 1'b1;
  logic        cts = 1'b0;
  logic        rxIrq;

  int checks = 0;
  int errors = 0;
  int divVal = 1;
  int bitT = 32;
  int rxCnt = 0;
  logic [7:0] lastData = '0;
  logic lastErr = 1'b0;
  bit mirrorOn = 1'b0;
  int mirrorBad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_port u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .txData(txData), .txValid(txValid), .txReady(txReady), .rxData(rxData),
    .rxValid(rxValid), .rxParityErr(rxParityErr), .txd(txd), .rxd(rxd), .cts(cts),
    .rxIrq(rxIrq)
  );

  always @(negedge clk) begin
    if (rxValid === 1'b1) begin
      rxCnt++;
      lastData = rxData;
      lastErr  = rxParityErr;
    end
    if (mirrorOn && (rxIrq !== rxValid)) mirrorBad++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic parOf(input logic [7:0] v, input logic odd);
    return (^v) ^ odd;
  endfunction

  function automatic logic [15:0] ctlWord(input bit en, cen, pe, odd, brk, two, lp, bi);
    return {8'h00, bi, lp, two, brk, odd, pe, cen, en};
  endfunction

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    @(negedge clk);
    txValid = 1'b1; txData = v;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic waitFall(output bit ok);
    int g = 0;
    while (txd !== 1'b0 && g < 20000) begin @(negedge clk); g++; end
    ok = (txd === 1'b0);
  endtask

  // Capture one frame on txd and compare to the expectation.
  task automatic captureTx(input logic [7:0] v, input bit pe, input bit odd, input bit two, input string req);
    logic [7:0] got;
    bit ok;
    logic p;
    waitFall(ok);
    check(ok, req, ok, 1);
    repeat (bitT / 2) @(negedge clk);
    check(txd === 1'b0, "R2 start", txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bitT) @(negedge clk);
      got[i] = txd;
    end
    check(got == v, req, got, v);
    if (pe) begin
      repeat (bitT) @(negedge clk);
      p = txd;
      check(p == parOf(v, odd), "R3/R4 tx parity", p, parOf(v, odd));
    end
    repeat (bitT) @(negedge clk);
    check(txd === 1'b1, "R2 stop", txd, 1);
    if (two) begin
      repeat (bitT) @(negedge clk);
      check(txd === 1'b1, "R5 second stop", txd, 1);
    end
  endtask

  task automatic txFrame(input logic [7:0] v, input bit pe, input bit odd, input bit two, input string req);
    fork
      sendByte(v);
      captureTx(v, pe, odd, two, req);
    join
  endtask

  task automatic driveRx(input logic [7:0] v, input bit pe, input bit odd, input bit flip);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bitT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = v[i];
      repeat (bitT) @(negedge clk);
    end
    if (pe) begin
      rxd = parOf(v, odd) ^ flip;
      repeat (bitT) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (bitT) @(negedge clk);
  endtask

  task automatic rxCheck(input logic [7:0] v, input bit pe, input bit odd, input bit flip);
    int c0 = rxCnt;
    driveRx(v, pe, odd, flip);
    check(rxCnt == c0 + 1, "R11 one rx byte", rxCnt - c0, 1);
    check(lastData == v, "R2 rx data", lastData, v);
    check(lastErr == (pe & flip), "R4 rx parity flag", lastErr, pe & flip);
  endtask

  // Time between the start edges of two back-to-back frames.
  task automatic periodCheck(input bit pe, input bit two, input string req);
    longint t0, t1;
    int nb, per;
    bit ok;
    nb = 10 + pe + two;
    fork
      begin
        @(negedge clk);
        txValid = 1'b1; txData = 8'h5A;
        while (!txReady) @(negedge clk);
        @(negedge clk);
        txData = 8'hA5;
        while (!txReady) @(negedge clk);
        @(negedge clk);
        txValid = 1'b0;
      end
      begin
        t0 = 0; t1 = 0;
        waitFall(ok);
        repeat ((nb - 1) * bitT + bitT / 2) begin @(negedge clk); t0++; end
        waitFallCount(t1);
        per = int'(t0 + t1);
        check((per >= nb * bitT - divVal - 2) && (per <= nb * bitT + divVal + 2), req, per, nb * bitT);
        repeat (nb * bitT) @(negedge clk);
      end
    join
  endtask

  task automatic waitFallCount(output longint n);
    n = 0;
    while (txd !== 1'b0 && n < 20000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0, lowCnt, irqCnt;
    bit readySeen, pe, odd, two, bi, flip;
    logic [7:0] v;
    void'($urandom(32'h5EED1234));

    repeat (3) @(negedge clk);
    check(txd === 1'b1 && txReady === 1'b0, "R1 tx reset", {txd, txReady}, 2);
    check(rxValid === 1'b0 && rxParityErr === 1'b0, "R1 rx reset", {rxValid, rxParityErr}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(txd === 1'b1 && txReady === 1'b0 && rxIrq === 1'b0, "R1 after reset", {txd, txReady, rxIrq}, 4);

    divVal = 1; bitT = 16 * (divVal + 1);
    wr(1'b1, 16'(divVal));

    // R12: disabled port ignores everything
    txValid = 1'b1; txData = 8'h33; readySeen = 0;
    repeat (100) begin @(negedge clk); if (txReady) readySeen = 1; end
    txValid = 1'b0;
    check(!readySeen, "R12 ready while disabled", readySeen, 0);
    c0 = rxCnt;
    driveRx(8'h96, 0, 0, 0);
    check(rxCnt == c0, "R12 rx while disabled", rxCnt - c0, 0);

    // R2 basic transmit
    wr(1'b0, ctlWord(1, 0, 0, 0, 0, 0, 0, 0));
    txFrame(8'hC3, 0, 0, 0, "R2 tx data");
    txFrame(8'h01, 0, 0, 0, "R2 tx lsb first");

    // R6 flow control
    wr(1'b0, ctlWord(1, 1, 0, 0, 0, 0, 0, 0));
    cts = 1'b0; txValid = 1'b1; txData = 8'h6E; readySeen = 0; lowCnt = 0;
    repeat (5 * bitT) begin @(negedge clk); if (txReady) readySeen = 1; if (!txd) lowCnt++; end
    txValid = 1'b0;
    check(!readySeen && lowCnt == 0, "R6 blocked by cts", readySeen + lowCnt, 0);
    cts = 1'b1;
    txFrame(8'h6E, 0, 0, 0, "R6 sends with cts");
    wr(1'b0, ctlWord(1, 0, 0, 0, 0, 0, 0, 0));
    cts = 1'b0;
    txFrame(8'h9B, 0, 0, 0, "R6 cts ignored");

    // R5 / R3 frame period
    periodCheck(0, 0, "R5 one stop period");
    wr(1'b0, ctlWord(1, 0, 0, 0, 0, 1, 0, 0));
    periodCheck(0, 1, "R5 two stop period");
    wr(1'b0, ctlWord(1, 0, 1, 1, 0, 1, 0, 0));
    periodCheck(1, 1, "R3 parity adds a bit");

    // R7 break mid-frame
    wr(1'b0, ctlWord(1, 0, 0, 0, 0, 0, 0, 0));
    sendByte(8'hFF);
    repeat (3 * bitT) @(negedge clk);
    wr(1'b0, ctlWord(1, 0, 0, 0, 1, 0, 0, 0));
    check(txd === 1'b0, "R7 break immediate", txd, 0);
    lowCnt = 0;
    repeat (2 * bitT) begin @(negedge clk); if (txd === 1'b0) lowCnt++; end
    check(lowCnt == 2 * bitT, "R7 break held", lowCnt, 2 * bitT);
    wr(1'b0, ctlWord(1, 0, 0, 0, 0, 0, 0, 0));
    check(txd === 1'b1 && txReady === 1'b1, "R7 frame abandoned", {txd, txReady}, 3);

    // R8 loopback
    wr(1'b0, ctlWord(1, 0, 1, 0, 0, 0, 1, 0));
    c0 = rxCnt; lowCnt = 0;
    fork
      sendByte(8'h4D);
      repeat (12 * bitT) begin @(negedge clk); if (txd !== 1'b1) lowCnt++; end
    join
    check(lowCnt == 0, "R8 txd idle in loopback", lowCnt, 0);
    check(rxCnt == c0 + 1 && lastData == 8'h4D, "R8 looped byte", lastData, 8'h4D);
    check(lastErr == 1'b0, "R8 looped parity", lastErr, 0);

    // R11 glitch rejection
    wr(1'b0, ctlWord(1, 0, 0, 0, 0, 0, 0, 0));
    c0 = rxCnt;
    @(negedge clk); rxd = 1'b0;
    repeat (3 * (divVal + 1)) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * bitT) @(negedge clk);
    check(rxCnt == c0, "R11 short low rejected", rxCnt - c0, 0);

    // Directed parity receive cases
    mirrorOn = 1'b1;
    wr(1'b0, ctlWord(1, 0, 1, 0, 0, 0, 0, 0));
    rxCheck(8'h07, 1, 0, 0);
    rxCheck(8'h07, 1, 0, 1);
    wr(1'b0, ctlWord(1, 0, 1, 1, 0, 0, 0, 1));
    rxCheck(8'h80, 1, 1, 0);
    rxCheck(8'hE1, 1, 1, 1);

    // Random receive and transmit
    for (int k = 0; k < 12; k++) begin
      v = 8'($urandom); pe = 1'($urandom); odd = 1'($urandom); flip = 1'($urandom); bi = 1'($urandom);
      wr(1'b0, ctlWord(1, 0, pe, odd, 0, 0, 0, bi));
      rxCheck(v, pe, odd, flip);
    end
    mirrorOn = 1'b0;
    check(mirrorBad == 0, "R10 irq mirrors rxValid", mirrorBad, 0);
    for (int k = 0; k < 12; k++) begin
      v = 8'($urandom); pe = 1'($urandom); odd = 1'($urandom); two = 1'($urandom);
      wr(1'b0, ctlWord(1, 0, pe, odd, 0, two, 0, 0));
      txFrame(v, pe, odd, two, "R2 random tx");
    end

    // R9 / R10 baud interrupt
    divVal = 4;
    wr(1'b1, 16'(divVal));
    wr(1'b0, ctlWord(0, 0, 0, 0, 0, 0, 0, 1));
    repeat (20) @(negedge clk);
    irqCnt = 0;
    repeat (100) begin @(negedge clk); if (rxIrq) irqCnt++; end
    check(irqCnt == 100 / (divVal + 1), "R9 baud irq rate", irqCnt, 100 / (divVal + 1));
    wr(1'b0, ctlWord(0, 0, 0, 0, 0, 0, 0, 0));
    irqCnt = 0;
    repeat (100) begin @(negedge clk); if (rxIrq) irqCnt++; end
    check(irqCnt == 0, "R9 baud irq off", irqCnt, 0);
    wr(1'b0, ctlWord(1, 0, 0, 0, 0, 0, 0, 1));
    irqCnt = 0;
    repeat (100) begin @(negedge clk); if (rxIrq) irqCnt++; end
    check(irqCnt == 0, "R10 baud irq ignored when enabled", irqCnt, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule